// File: doc/BRIEF.md
# Match-Compare Watchdog Timer

The block is a watchdog timer inside a chip. A free-running up-counter advances once per counter-clock tick and is compared with a programmable match value. When the counter reaches that value, the block can latch an interrupt flag, freeze the counter, change the level of an external match pin, and start a reset pulse on a system reset output, an external reset output, or both. The pulse length comes from a register, so software can set how long the reset lasts in counter-clock ticks.

Software reaches eight 32-bit words through a small register bus. Writes complete in one cycle and reads are combinational. To start the watchdog, software first clears the counter. It sets the clear-request bit, polls the counter until it reads zero, and then enables counting. The clear takes effect only on the next counter tick, so software can see the delay. A sticky boot-cause bit records that the watchdog has driven a system reset. Only the power-on reset input clears it, so the bit survives the reset that the block itself produced.

Top module: `wdm_timer_top`

## Requirements
- R1: The word map is: 0 interrupt status, 1 control, 2 counter, 3 match control, 4 match value, 5 external match, 6 pulse length, 7 reset status. After power-on reset every word reads 0 and `irq`, `sys_rst_out`, `ext_rst_out` and `match_out` are low.
- R2: When control bit 0 (count enable) is set, the counter advances by one on each tick. Writing 0 to control holds the counter value. Writes to the counter word have no effect.
- R3: While control bit 1 (clear request) is set, the counter is not cleared by the write itself. It goes to 0 on the next tick and stays 0 while the bit remains set, even if bit 0 is also set.
- R4: With control bit 2 (debug freeze) set, the counter does not advance while `dbg_halt` is high. With bit 2 clear, `dbg_halt` has no effect.
- R5: When match-control bit 0 is set, status bit 0 sets on the tick where the counter advances to the match value, and `irq` follows that bit. Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged.
- R6: With match-control bit 2 set, the counter stops once it equals the match value and raises no further match event.
- R7: On a match event, match-control bit 3 starts a pulse on `sys_rst_out` and bit 4 starts a pulse on `ext_rst_out`. Bits 5 and 6 force the same two pulses. Each pulse lasts the pulse-length value plus 6 ticks, so 0xFFFF gives 65541 ticks.
- R8: A trigger that arrives while a pulse is running neither restarts nor lengthens that pulse.
- R9: The external match word holds the pin level in bit 0 and a match action in bits 5:4. The actions are 0 keep, 1 drive low, 2 drive high and 3 toggle. The action is applied on each match event, and `match_out` equals bit 0.
- R10: Reset-status bit 0 sets when `sys_rst_out` is driven. It ignores bus writes and clears only through `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| tick | input | 1 | Counter-clock enable, one pulse per counter tick |
| dbg_halt | input | 1 | Debugger halt indication |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_word | input | 3 | Word index of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the word at `bus_word` |
| irq | output | 1 | Match interrupt flag |
| sys_rst_out | output | 1 | System reset pulse |
| ext_rst_out | output | 1 | External reset pulse |
| match_out | output | 1 | External match pin level |

## Verification
The assertions assume that `rst_n` is released away from a clock edge and that `tick`, `dbg_halt` and the bus inputs change only between edges. The bench drives every input on the falling edge to keep to this. The countdown property assumes that a running pulse is never reloaded. The bench tests this by sending a second force trigger in the middle of a pulse. The counting checks rely on exact tick counts, so the bench holds `tick` low during register setup and releases a known number of ticks afterwards.

// File: rtl/wdm_pkg.sv
package wdm_pkg;

  localparam int unsigned WORD_IDX_W = 3;

  localparam logic [WORD_IDX_W-1:0] W_STATUS = 3'd0;
  localparam logic [WORD_IDX_W-1:0] W_CTRL   = 3'd1;
  localparam logic [WORD_IDX_W-1:0] W_COUNT  = 3'd2;
  localparam logic [WORD_IDX_W-1:0] W_MCTRL  = 3'd3;
  localparam logic [WORD_IDX_W-1:0] W_MATCH  = 3'd4;
  localparam logic [WORD_IDX_W-1:0] W_PINCTL = 3'd5;
  localparam logic [WORD_IDX_W-1:0] W_PULSE  = 3'd6;
  localparam logic [WORD_IDX_W-1:0] W_BOOT   = 3'd7;

  typedef struct packed {
    logic freeze_dbg;
    logic clr_req;
    logic run;
  } wdm_ctrl_t;

  typedef struct packed {
    logic force_ext;
    logic force_sys;
    logic ext_on_hit;
    logic sys_on_hit;
    logic halt_on_hit;
    logic spare;
    logic irq_on_hit;
  } wdm_mctrl_t;

  typedef enum logic [1:0] {
    PIN_KEEP   = 2'd0,
    PIN_LOW    = 2'd1,
    PIN_HIGH   = 2'd2,
    PIN_TOGGLE = 2'd3
  } wdm_pin_act_e;

  localparam int unsigned N_RST_OUT = 2;
  localparam int unsigned RST_SYS   = 0;
  localparam int unsigned RST_EXT   = 1;

endpackage

// File: rtl/wdm_counter.sv
module wdm_counter
  import wdm_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             dbg_halt,
  input  wdm_ctrl_t        ctrl,
  input  logic             halt_on_hit,
  input  logic [CNT_W-1:0] match_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             hit
);

  logic [CNT_W-1:0] cnt_nx;
  logic [CNT_W-1:0] cnt_inc;
  logic             frozen;
  logic             parked;
  logic             step;

  always_comb begin
    cnt_inc = cnt_q + CNT_W'(1);
    frozen  = ctrl.freeze_dbg & dbg_halt;
    parked  = halt_on_hit & (cnt_q == match_val);
    step    = tick & ctrl.run & ~ctrl.clr_req & ~frozen & ~parked;
    hit     = step & (cnt_inc == match_val);
    if (tick && ctrl.clr_req) begin
      cnt_nx = '0;
    end else if (step) begin
      cnt_nx = cnt_inc;
    end else begin
      cnt_nx = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_nx;
    end
  end

  // R3: a tick with clear request pending leaves zero behind
  a_r3_clear_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ctrl.clr_req) |=> (cnt_q == '0));

  // R2: without run and without clear the value is held
  a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !ctrl.clr_req) |=> $stable(cnt_q));

  // R4: debug freeze holds the value
  a_r4_debug_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.freeze_dbg && dbg_halt && !ctrl.clr_req) |=> $stable(cnt_q));

  // R6: parked at the match value
  a_r6_park_at_match: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_on_hit && (cnt_q == match_val) && !ctrl.clr_req) |=> $stable(cnt_q));

endmodule

// File: rtl/wdm_pulse.sv
module wdm_pulse #(
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned EXTRA_T = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             trig,
  input  logic [LEN_W-1:0] len,
  output logic             active_q
);

  localparam int unsigned REM_W = LEN_W + 1;

  logic [REM_W-1:0] rem_q;
  logic [REM_W-1:0] rem_nx;
  logic             active_nx;

  always_comb begin
    rem_nx    = rem_q;
    active_nx = active_q;
    if (!active_q) begin
      if (trig) begin
        active_nx = 1'b1;
        rem_nx    = {1'b0, len} + REM_W'(EXTRA_T - 1);
      end
    end else if (tick) begin
      if (rem_q == '0) begin
        active_nx = 1'b0;
      end else begin
        rem_nx = rem_q - REM_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rem_q    <= '0;
    end else begin
      active_q <= active_nx;
      rem_q    <= rem_nx;
    end
  end

  // R8: a running pulse only counts down, a new trigger never reloads it
  a_r8_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && tick && (rem_q != '0)) |=> (active_q && (rem_q == $past(rem_q) - REM_W'(1))));

endmodule

// File: rtl/wdm_regs.sv
module wdm_regs
  import wdm_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned LEN_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel,
  input  logic                  wr,
  input  logic [WORD_IDX_W-1:0] word,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata,
  input  logic                  hit,
  input  logic [CNT_W-1:0]      cnt_val,
  input  logic                  sys_pulse,
  output wdm_ctrl_t             ctrl_q,
  output logic                  halt_on_hit,
  output logic [N_RST_OUT-1:0]  rst_on_hit,
  output logic [N_RST_OUT-1:0]  rst_force,
  output logic [CNT_W-1:0]      match_q,
  output logic [LEN_W-1:0]      len_q,
  output logic                  irq_q,
  output logic                  pin_q,
  output logic                  boot_q
);

  wdm_mctrl_t   mctrl_q, mctrl_nx;
  wdm_ctrl_t    ctrl_nx;
  wdm_pin_act_e act_q, act_nx;
  logic [CNT_W-1:0] match_nx;
  logic [LEN_W-1:0] len_nx;
  logic irq_nx, pin_nx, boot_nx, pin_base;
  logic we;

  always_comb begin
    we       = sel & wr;
    ctrl_nx  = ctrl_q;
    mctrl_nx = mctrl_q;
    match_nx = match_q;
    len_nx   = len_q;
    act_nx   = act_q;
    pin_base = pin_q;
    if (we) begin
      unique case (word)
        W_CTRL:   ctrl_nx  = wdm_ctrl_t'(wdata[2:0]);
        W_MCTRL:  mctrl_nx = wdm_mctrl_t'(wdata[6:0]);
        W_MATCH:  match_nx = wdata[CNT_W-1:0];
        W_PULSE:  len_nx   = wdata[LEN_W-1:0];
        W_PINCTL: begin
          pin_base = wdata[0];
          act_nx   = wdm_pin_act_e'(wdata[5:4]);
        end
        default: ;
      endcase
    end
    pin_nx = pin_base;
    if (hit) begin
      unique case (act_nx)
        PIN_LOW:    pin_nx = 1'b0;
        PIN_HIGH:   pin_nx = 1'b1;
        PIN_TOGGLE: pin_nx = ~pin_base;
        default:    pin_nx = pin_base;
      endcase
    end
    irq_nx = irq_q;
    if (we && (word == W_STATUS) && wdata[0]) begin
      irq_nx = 1'b0;
    end
    if (hit && mctrl_q.irq_on_hit) begin
      irq_nx = 1'b1;
    end
    boot_nx = boot_q | sys_pulse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      mctrl_q <= '0;
      match_q <= '0;
      len_q   <= '0;
      act_q   <= PIN_KEEP;
      pin_q   <= 1'b0;
      irq_q   <= 1'b0;
      boot_q  <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_nx;
      mctrl_q <= mctrl_nx;
      match_q <= match_nx;
      len_q   <= len_nx;
      act_q   <= act_nx;
      pin_q   <= pin_nx;
      irq_q   <= irq_nx;
      boot_q  <= boot_nx;
    end
  end

  always_comb begin
    halt_on_hit         = mctrl_q.halt_on_hit;
    rst_on_hit[RST_SYS] = mctrl_q.sys_on_hit;
    rst_on_hit[RST_EXT] = mctrl_q.ext_on_hit;
    rst_force[RST_SYS]  = mctrl_q.force_sys;
    rst_force[RST_EXT]  = mctrl_q.force_ext;
  end

  always_comb begin
    unique case (word)
      W_STATUS: rdata = DATA_W'(irq_q);
      W_CTRL:   rdata = DATA_W'(ctrl_q);
      W_COUNT:  rdata = DATA_W'(cnt_val);
      W_MCTRL:  rdata = DATA_W'(mctrl_q);
      W_MATCH:  rdata = DATA_W'(match_q);
      W_PINCTL: rdata = DATA_W'({act_q, 3'b000, pin_q});
      W_PULSE:  rdata = DATA_W'(len_q);
      default:  rdata = DATA_W'(boot_q);
    endcase
  end

  // R5: an enabled match event always leaves the flag set
  a_r5_flag_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mctrl_q.irq_on_hit) |=> irq_q);

  // R10: the boot-cause bit never falls while rst_n is high
  a_r10_boot_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    boot_q |=> boot_q);

  // R10: a system pulse always records the boot cause
  a_r10_boot_set: assert property (@(posedge clk) disable iff (!rst_n)
    sys_pulse |=> boot_q);

endmodule

// File: rtl/wdm_timer_top.sv
module wdm_timer_top
  import wdm_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned EXTRA_T = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              dbg_halt,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [2:0]        bus_word,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              sys_rst_out,
  output logic              ext_rst_out,
  output logic              match_out
);

  wdm_ctrl_t            ctrl;
  logic                 halt_on_hit;
  logic [N_RST_OUT-1:0] rst_on_hit;
  logic [N_RST_OUT-1:0] rst_force;
  logic [N_RST_OUT-1:0] pulse_act;
  logic [CNT_W-1:0]     match_val;
  logic [CNT_W-1:0]     cnt_val;
  logic [LEN_W-1:0]     len_val;
  logic                 hit;
  logic                 boot;

  wdm_regs #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .LEN_W  (LEN_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel         (bus_sel),
    .wr          (bus_wr),
    .word        (bus_word),
    .wdata       (bus_wdata),
    .rdata       (bus_rdata),
    .hit         (hit),
    .cnt_val     (cnt_val),
    .sys_pulse   (pulse_act[RST_SYS]),
    .ctrl_q      (ctrl),
    .halt_on_hit (halt_on_hit),
    .rst_on_hit  (rst_on_hit),
    .rst_force   (rst_force),
    .match_q     (match_val),
    .len_q       (len_val),
    .irq_q       (irq),
    .pin_q       (match_out),
    .boot_q      (boot)
  );

  wdm_counter #(
    .CNT_W (CNT_W)
  ) u_counter (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .dbg_halt    (dbg_halt),
    .ctrl        (ctrl),
    .halt_on_hit (halt_on_hit),
    .match_val   (match_val),
    .cnt_q       (cnt_val),
    .hit         (hit)
  );

  for (genvar g = 0; g < N_RST_OUT; g++) begin : g_pulse
    wdm_pulse #(
      .LEN_W   (LEN_W),
      .EXTRA_T (EXTRA_T)
    ) u_pulse (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .trig     ((hit & rst_on_hit[g]) | rst_force[g]),
      .len      (len_val),
      .active_q (pulse_act[g])
    );
  end

  assign sys_rst_out = pulse_act[RST_SYS];
  assign ext_rst_out = pulse_act[RST_EXT];

  // R10: a system pulse cannot run without the boot cause following it
  a_r10_boot_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sys_rst_out) |-> boot);

endmodule

// File: tb/test_wdm_timer_top.sv
module test_wdm_timer_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic        dbg_halt;
  logic        bus_sel;
  logic        bus_wr;
  logic [2:0]  bus_word;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq, sys_rst_out, ext_rst_out, match_out;

  int tests = 0;
  int fails = 0;
  int hi_sys = 0;
  int hi_ext = 0;
  bit done = 0;

  wdm_timer_top i_wdm_timer_top (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .dbg_halt    (dbg_halt),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_word    (bus_word),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .irq         (irq),
    .sys_rst_out (sys_rst_out),
    .ext_rst_out (ext_rst_out),
    .match_out   (match_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (sys_rst_out) hi_sys++;
    if (ext_rst_out) hi_ext++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] w, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_word = w; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] w, output logic [31:0] d);
    @(negedge clk);
    bus_word = w;
    #1 d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic clr_cnt();
    wr(3'd1, 32'h2);
    ticks(1);
    wr(3'd1, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), v);
      chk($sformatf("R1 word %0d after reset", i), v, 32'h0);
    end
    chk("R1 outputs low", {28'h0, irq, sys_rst_out, ext_rst_out, match_out}, 32'h0);
  endtask

  task automatic t_count();
    logic [31:0] v;
    wr(3'd1, 32'h1);
    ticks(5);
    rd(3'd2, v); chk("R2 counts five ticks", v, 32'd5);
    wr(3'd1, 32'h0);
    ticks(4);
    rd(3'd2, v); chk("R2 held with control 0", v, 32'd5);
    wr(3'd2, 32'h55);
    rd(3'd2, v); chk("R2 counter write ignored", v, 32'd5);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(3'd1, 32'h2);
    rd(3'd2, v); chk("R3 not cleared before tick", v, 32'd5);
    ticks(1);
    rd(3'd2, v); chk("R3 zero after tick", v, 32'd0);
    wr(3'd1, 32'h1);
    ticks(3);
    rd(3'd2, v); chk("R3 restarts from zero", v, 32'd3);
    wr(3'd1, 32'h3);
    ticks(2);
    rd(3'd2, v); chk("R3 clear beats run", v, 32'd0);
    wr(3'd1, 32'h0);
  endtask

  task automatic t_debug();
    logic [31:0] v;
    dbg_halt = 1'b1;
    wr(3'd1, 32'h5);
    ticks(4);
    rd(3'd2, v); chk("R4 frozen by debug halt", v, 32'd0);
    wr(3'd1, 32'h1);
    ticks(2);
    rd(3'd2, v); chk("R4 halt ignored without bit 2", v, 32'd2);
    dbg_halt = 1'b0;
    wr(3'd1, 32'h5);
    ticks(2);
    rd(3'd2, v); chk("R4 runs when halt low", v, 32'd4);
    wr(3'd1, 32'h0);
  endtask

  task automatic t_match();
    logic [31:0] v;
    clr_cnt();
    wr(3'd4, 32'd10);
    wr(3'd3, 32'h1);
    wr(3'd1, 32'h1);
    ticks(9);
    chk("R5 no flag before match", {31'h0, irq}, 32'h0);
    ticks(1);
    chk("R5 irq on match", {31'h0, irq}, 32'h1);
    rd(3'd0, v); chk("R5 status bit set", v, 32'h1);
    ticks(3);
    rd(3'd2, v); chk("R6 counts past match without stop", v, 32'd13);
    wr(3'd0, 32'h0);
    chk("R5 write 0 keeps flag", {31'h0, irq}, 32'h1);
    wr(3'd0, 32'h1);
    chk("R5 write 1 clears flag", {31'h0, irq}, 32'h0);
    clr_cnt();
    wr(3'd3, 32'h5);
    wr(3'd1, 32'h1);
    ticks(15);
    rd(3'd2, v); chk("R6 stops at match", v, 32'd10);
    chk("R6 flag set at stop", {31'h0, irq}, 32'h1);
    wr(3'd0, 32'h1);
    ticks(5);
    rd(3'd2, v); chk("R6 remains stopped", v, 32'd10);
    chk("R6 no repeat event", {31'h0, irq}, 32'h0);
    wr(3'd3, 32'h0);
    ticks(2);
    rd(3'd2, v); chk("R6 resumes when released", v, 32'd12);
    wr(3'd1, 32'h0);
  endtask

  task automatic pin_case(input logic [31:0] pinw, input logic exp_pin, input logic [31:0] exp_word, input string tag);
    logic [31:0] v;
    wr(3'd1, 32'h0);
    clr_cnt();
    wr(3'd5, pinw);
    wr(3'd1, 32'h1);
    ticks(4);
    chk({"R9 pin ", tag}, {31'h0, match_out}, {31'h0, exp_pin});
    rd(3'd5, v); chk({"R9 word ", tag}, v, exp_word);
  endtask

  task automatic t_pin();
    wr(3'd4, 32'd4);
    pin_case(32'h20, 1'b1, 32'h21, "drive high");
    pin_case(32'h31, 1'b0, 32'h30, "toggle");
    pin_case(32'h11, 1'b0, 32'h10, "drive low");
    pin_case(32'h01, 1'b1, 32'h01, "keep");
    wr(3'd1, 32'h0);
  endtask

  task automatic t_pulse();
    logic [31:0] v;
    tick = 1'b1;
    rd(3'd7, v); chk("R10 clear before any pulse", v, 32'h0);
    wr(3'd6, 32'd3);
    hi_sys = 0; hi_ext = 0;
    wr(3'd3, 32'h20); wr(3'd3, 32'h0);
    repeat (30) @(negedge clk);
    chk("R7 forced system pulse length", 32'(hi_sys), 32'd9);
    chk("R7 external untouched", 32'(hi_ext), 32'd0);
    rd(3'd7, v); chk("R10 set by system pulse", v, 32'h1);
    hi_sys = 0; hi_ext = 0;
    wr(3'd3, 32'h40); wr(3'd3, 32'h0);
    repeat (30) @(negedge clk);
    chk("R7 forced external pulse length", 32'(hi_ext), 32'd9);
    chk("R7 system untouched", 32'(hi_sys), 32'd0);
    hi_sys = 0;
    wr(3'd3, 32'h20); wr(3'd3, 32'h0);
    repeat (2) @(negedge clk);
    wr(3'd3, 32'h20); wr(3'd3, 32'h0);
    repeat (30) @(negedge clk);
    chk("R8 retrigger ignored", 32'(hi_sys), 32'd9);
    wr(3'd1, 32'h2); wr(3'd1, 32'h0);
    wr(3'd4, 32'd20);
    wr(3'd6, 32'd0);
    hi_sys = 0; hi_ext = 0;
    wr(3'd3, 32'h18);
    wr(3'd1, 32'h1);
    repeat (60) @(negedge clk);
    chk("R7 match system pulse", 32'(hi_sys), 32'd6);
    chk("R7 match external pulse", 32'(hi_ext), 32'd6);
    wr(3'd1, 32'h0);
    wr(3'd3, 32'h0);
    wr(3'd6, 32'hFFFF);
    hi_sys = 0;
    wr(3'd3, 32'h20); wr(3'd3, 32'h0);
    repeat (65560) @(negedge clk);
    chk("R7 longest pulse", 32'(hi_sys), 32'd65541);
    wr(3'd7, 32'h0);
    rd(3'd7, v); chk("R10 write ignored", v, 32'h1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(3'd7, v); chk("R10 cleared by power-on reset", v, 32'h0);
    tick = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b0; dbg_halt = 1'b0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_word = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_count();
    t_clear();
    t_debug();
    t_match();
    t_pin();
    t_pulse();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule